// File: doc/BRIEF.md
# Banked Decimating FIR Filter

This block is a programmable FIR filter for a receive chain. It takes signed 20-bit samples and convolves them with up to 128 signed 16-bit coefficients. A single multiplier-accumulator is shared over successive clock cycles, one tap per clock, so each output costs as many clocks as there are taps. The coefficients live in four independent banks. Any bank can be rewritten through a write port while another bank drives the filter, and a select input picks which bank the next output uses.

The filter decimates by an integer factor M2. It counts incoming samples and starts a convolution only for every M2-th sample, so no work is spent on outputs that would be thrown away. The 42-bit sum is reduced to a 16-bit result through a programmable right shift with truncation, and the result saturates when the shifted value does not fit.

Top module: `banked_dec_fir`

## Requirements
- R1: After reset `out_valid` is 0 and every stored past sample reads as zero, so outputs computed before 128 samples have arrived treat the missing history as 0.
- R2: For a kept sample x[n], the accumulated value is the sum over k = 0..T-1 of c[b][k]·x[n-k]. Samples and coefficients are two's-complement, the sum is 42 bits, and T = `num_taps`. A `num_taps` of 0 acts as 1 and values above 128 act as 128.
- R3: The first `in_valid` sample after reset is kept, and after it every M2-th valid sample is kept, with M2 = `decim` (0 acts as 1). Only kept samples produce an output.
- R4: `out_valid` is a one-cycle pulse that rises exactly T clock edges after the edge that accepted the kept sample.
- R5: The bank (`bank_sel`), T and the shift are captured at the edge that accepts a kept sample. Later changes to any of them do not alter the output in progress.
- R6: When `coef_we` is 1, `coef_data` is written into bank `coef_bank` at index `coef_idx` at that edge. A write at the same edge as a kept sample is already used by that sample's output.
- R7: Before saturation, `out_data` = floor(sum / 2^S), with S = `shift` in 0..26 and values above 26 acting as 26.
- R8: When the shifted sum is above 32767, `out_data` is 32767 (0x7FFF). When it is below -32768, `out_data` is -32768 (0x8000).
- R9: Samples may arrive on every clock while an output is being computed without changing that output. Kept samples must be at least T+1 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 20 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_bank | input | 2 | Bank addressed by the write |
| coef_idx | input | 7 | Tap index addressed by the write |
| coef_data | input | 16 | Signed coefficient value |
| bank_sel | input | 2 | Bank used by the next kept sample |
| num_taps | input | 8 | Tap count T (1..128) |
| shift | input | 5 | Right shift S of the sum (0..26) |
| decim | input | 8 | Decimation factor M2 |
| out_valid | output | 1 | Output strobe |
| out_data | output | 16 | Signed, shifted, saturated result |

## Verification
Three things can happen at the same edge. A kept sample can start a convolution while a coefficient write and a bank switch land on that edge, and new samples can be written into the history buffer while the multiplier is still reading older ones. The bench provokes the first case by applying a bank switch, a write to the newly selected bank and a kept sample in one cycle, then checks that the output reflects the written coefficient. It provokes the second case by streaming a sample every clock with 128 taps, so each write lands on the slot the multiplier reads at that edge, and compares every result against a model built from the full sample history.

// File: rtl/banked_dec_fir.sv
module banked_dec_fir #(
  parameter int DW    = 20,
  parameter int CW    = 16,
  parameter int AW    = 42,
  parameter int OW    = 16,
  parameter int MAXT  = 128,
  parameter int NB    = 4,
  parameter int MAXSH = 26,
  parameter int DECW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 coef_we,
  input  logic [$clog2(NB)-1:0]   coef_bank,
  input  logic [$clog2(MAXT)-1:0] coef_idx,
  input  logic signed [CW-1:0] coef_data,
  input  logic [$clog2(NB)-1:0]   bank_sel,
  input  logic [$clog2(MAXT):0]   num_taps,
  input  logic [$clog2(MAXSH+1)-1:0] shift,
  input  logic [DECW-1:0]      decim,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int AB = $clog2(MAXT);
  localparam int BB = $clog2(NB);
  localparam int TW = AB + 1;
  localparam int SW = $clog2(MAXSH + 1);
  localparam int PW = DW + CW;

  logic signed [DW-1:0] smem [MAXT];
  logic signed [CW-1:0] cmem [NB*MAXT];
  logic [AB-1:0]   wp, base_q, k;
  logic [BB-1:0]   bank_q;
  logic [SW-1:0]   shq;
  logic [DECW-1:0] dcnt;
  logic            busy;
  logic signed [AW-1:0] acc;

  wire [TW-1:0] tap_eff = (num_taps == '0) ? TW'(1) :
                          (num_taps > TW'(MAXT)) ? TW'(MAXT) : num_taps;
  wire [SW-1:0] sh_eff  = (shift > SW'(MAXSH)) ? SW'(MAXSH) : shift;
  wire [DECW-1:0] dec_eff = (decim == '0) ? DECW'(1) : decim;
  wire [DECW:0] dinc    = {1'b0, dcnt} + 1'b1;
  wire          kept    = in_valid && (dcnt == '0);
  wire          start   = kept && !busy;

  wire [AB-1:0] rd = base_q - k;
  wire signed [DW-1:0] xs = smem[rd];
  wire signed [CW-1:0] cs = cmem[{bank_q, k}];
  wire signed [PW-1:0] prod = xs * cs;
  wire signed [AW-1:0] fin = acc + {{(AW-PW){prod[PW-1]}}, prod};
  wire signed [AW-1:0] shd = fin >>> shq;
  wire [AW-OW:0] hi = shd[AW-1:OW-1];
  wire fits = (&hi) || !(|hi);
  wire signed [OW-1:0] sat = fits ? shd[OW-1:0] :
                             shd[AW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      dcnt <= '0;
      for (int i = 0; i < MAXT; i++) smem[i] <= '0;
    end else if (in_valid) begin
      smem[wp] <= in_data;
      wp       <= wp + 1'b1;
      dcnt     <= (dinc >= {1'b0, dec_eff}) ? '0 : dinc[DECW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (coef_we) cmem[{coef_bank, coef_idx}] <= coef_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      acc       <= '0;
      k         <= '0;
      base_q    <= '0;
      bank_q    <= '0;
      shq       <= '0;
    end else begin
      out_valid <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        acc    <= '0;
        base_q <= wp;
        bank_q <= bank_sel;
        shq    <= sh_eff;
        k      <= AB'(tap_eff - 1'b1);
      end else if (busy) begin
        acc <= fin;
        if (k == '0) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= sat;
        end else begin
          k <= k - 1'b1;
        end
      end
    end
  end

  assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bank_q) && $stable(shq));
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !busy && $past(busy));
  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kept |-> !busy);
  assert_kept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: tb/banked_dec_fir_test.sv
module banked_dec_fir_test;
  localparam int CLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, coef_we = 1'b0;
  logic signed [19:0] in_data = '0;
  logic [1:0] coef_bank = '0, bank_sel = '0;
  logic [6:0] coef_idx = '0;
  logic signed [15:0] coef_data = '0;
  logic [7:0] num_taps = 8'd1, decim = 8'd1;
  logic [4:0] shift = '0;
  logic out_valid;
  logic signed [15:0] out_data;

  int checks = 0, fails = 0, cyc = 0, mcnt = 0, nout = 0;
  int seed = 12345;
  string tag = "R1";
  longint cm [4][128];
  longint hist [$];
  longint exp_q [$];
  int exp_c [$];

  banked_dec_fir uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_bank(coef_bank), .coef_idx(coef_idx), .coef_data(coef_data),
    .bank_sel(bank_sel), .num_taps(num_taps), .shift(shift), .decim(decim),
    .out_valid(out_valid), .out_data(out_data));

  always #(CLK/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic int teff();
    if (num_taps == 0) return 1;
    if (num_taps > 128) return 128;
    return int'(num_taps);
  endfunction

  function automatic longint model();
    longint a = 0, v;
    int n = hist.size() - 1;
    int s = (shift > 26) ? 26 : int'(shift);
    for (int k = 0; k < teff(); k++)
      if (n - k >= 0) a += cm[bank_sel][k] * hist[n-k];
    v = a >>> s;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return seed >>> 8;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      nout++;
      if (exp_q.size() == 0) check(0, {tag, " unexpected out_valid"}, 1, 0);
      else begin
        check($signed(out_data) == exp_q[0], {tag, " out_data"}, $signed(out_data), exp_q[0]);
        check(cyc == exp_c[0], "R4 output cycle", cyc, exp_c[0]);
        void'(exp_q.pop_front());
        void'(exp_c.pop_front());
      end
    end
  end

  task automatic step(input bit v, input longint d, input bit we, input int wb, input int wi, input longint wd);
    in_valid = v; in_data = d[19:0];
    coef_we = we; coef_bank = wb[1:0]; coef_idx = wi[6:0]; coef_data = wd[15:0];
    if (we) cm[wb][wi] = longint'($signed(wd[15:0]));
    if (v) begin
      hist.push_back(longint'($signed(d[19:0])));
      if (mcnt == 0) begin
        exp_q.push_back(model());
        exp_c.push_back(cyc + 1 + teff());
      end
      mcnt = (mcnt + 1 >= ((decim == 0) ? 1 : int'(decim))) ? 0 : mcnt + 1;
    end
    @(negedge clk);
    in_valid = 0; coef_we = 0;
  endtask

  task automatic put(input longint d); step(1, d, 0, 0, 0, 0); endtask
  task automatic wr(input int b, input int i, input longint v); step(0, 0, 1, b, i, v); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0); endtask

  task automatic drain(input int expn);
    idle(140);
    check(exp_q.size() == 0, {tag, " pending outputs"}, exp_q.size(), 0);
    check(nout == expn, {tag, " output count"}, nout, expn);
  endtask

  task automatic do_reset();
    rst_n = 0; hist.delete(); exp_q.delete(); exp_c.delete(); mcnt = 0; nout = 0;
    idle(3);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    tag = "R1";
    rst_n = 0; @(negedge clk); @(negedge clk);
    check(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    do_reset();
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
  endtask

  task automatic t_impulse();
    tag = "R2 impulse";
    num_taps = 8; decim = 1; shift = 0; bank_sel = 0;
    for (int i = 0; i < 8; i++) wr(0, i, (i + 1) * 100 - 450);
    do_reset();
    put(1);
    for (int i = 0; i < 8; i++) begin idle(9); put(0); end
    drain(9);
  endtask

  task automatic t_banks();
    tag = "R5 banks";
    num_taps = 4; decim = 1; shift = 0;
    for (int b = 0; b < 4; b++) for (int i = 0; i < 4; i++) wr(b, i, (b + 1) * 1000 + i);
    do_reset();
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b);
      put(b * 37 - 50);
      bank_sel = 2'(3 - b); num_taps = 2; shift = 3;
      idle(5);
      num_taps = 4; shift = 0;
    end
    drain(4);
  endtask

  task automatic t_decim();
    tag = "R3 decim";
    num_taps = 2; decim = 3; shift = 2; bank_sel = 1;
    wr(1, 0, -7); wr(1, 1, 11);
    do_reset();
    for (int i = 0; i < 12; i++) put(i * 1000 - 5000);
    drain(4);
  endtask

  task automatic t_full();
    tag = "R9 full stream";
    num_taps = 128; decim = 129; shift = 12; bank_sel = 3;
    for (int i = 0; i < 128; i++) wr(3, i, longint'(rnd() % 32768));
    do_reset();
    for (int i = 0; i < 300; i++) put(longint'(rnd() % 524288));
    drain(3);
  endtask

  task automatic t_sat();
    tag = "R8 saturate";
    num_taps = 4; decim = 1; shift = 0; bank_sel = 2;
    for (int i = 0; i < 4; i++) wr(2, i, 32767);
    do_reset();
    for (int i = 0; i < 4; i++) begin put(524287); idle(5); end
    for (int i = 0; i < 4; i++) begin put(-524288); idle(5); end
    drain(8);
    tag = "R7 shift clamp";
    shift = 30;
    do_reset();
    for (int i = 0; i < 4; i++) begin put(524287); idle(5); end
    put(-524288); idle(5);
    drain(5);
  endtask

  task automatic t_same_cycle();
    tag = "R6 same cycle";
    num_taps = 3; decim = 1; shift = 0; bank_sel = 0;
    for (int b = 0; b < 2; b++) for (int i = 0; i < 3; i++) wr(b, i, b * 10 + i + 1);
    do_reset();
    put(9); idle(4);
    bank_sel = 1;
    step(1, 500, 1, 1, 0, -3000);
    bank_sel = 0;
    step(0, 0, 1, 0, 0, 29000);
    idle(4);
    put(-7); idle(4);
    drain(3);
  endtask

  initial begin
    #(CLK * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) for (int i = 0; i < 128; i++) cm[b][i] = 0;
    @(negedge clk);
    for (int b = 0; b < 4; b++) for (int i = 0; i < 128; i++) wr(b, i, 0);
    t_reset();
    t_impulse();
    t_banks();
    t_decim();
    t_full();
    t_sat();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule